// File: doc/BRIEF.md
# Privileged Trap Entry and Return Controller

This block is the part of a three-level core (machine, supervisor, user) that takes a trap and comes back from one. An upstream stage hands it one event at a time: a synchronous exception, an asynchronous interrupt, a machine-level return or a supervisor-level return. Exceptions and interrupts carry a cause number, the address of the affected instruction and a trap value. The controller decides which level handles a trap, using two delegation masks, one for exceptions and one for interrupts. It then updates that level's saved-PC, cause and trap-value registers and the shared status word, and changes the current privilege. Each accepted event produces one redirect item with the new fetch address and the new privilege.

Events enter on a valid/ready handshake. An event is taken on a rising edge where `ev_valid` and `ev_ready` are both high. Redirects leave on a second valid/ready handshake. A redirect stays on the outputs, unchanged, until `rd_ready` is seen high. While a redirect is pending, `ev_ready` is low, so at most one redirect is ever in flight and events back up behind a stalled consumer. A plain CSR port lets software set the vectors, the delegation masks and the status fields, and read back all of the state.

Top module: `trap_unit`

## Requirements
- R1: After reset the current privilege is M (2'b11), `rd_valid` is low, `ev_ready` is high, and every CSR reads as zero.
- R2: An exception (ev_kind 0) whose bit is set in the exception delegation mask (0x302), or an interrupt (ev_kind 1) whose bit is set in the interrupt delegation mask (0x303), is handled in S (2'b01) when it is taken from S or U (2'b00). All other traps go to M. A trap taken in M always stays in M.
- R3: On trap entry the target level's saved PC (M 0x341 / S 0x141) takes `ev_pc` and its trap value (0x343 / 0x143) takes `ev_tval`. Its cause register (0x342 / 0x142) takes the cause number in its low bits and bit XLEN-1 set for an interrupt. The other level's registers do not change.
- R4: Entry to M copies MIE (status bit 3) into MPIE (bit 7), clears MIE, and stores the old privilege in MPP (bits 12:11). Entry to S copies SIE (bit 1) into SPIE (bit 5), clears SIE, and sets SPP (bit 8) to 1 if and only if the old privilege was S.
- R5: One cycle after an event is accepted, `rd_valid` is high and `rd_priv` and `cur_priv` both show the new privilege. For a trap, `rd_pc` is the target vector (0x305 or 0x105) with its two low bits cleared.
- R6: A machine return (ev_kind 2) moves to the privilege held in MPP. It sets MIE to MPIE, sets MPIE to 1 and MPP to U, clears MPRV (bit 17) when MPP was not M, and redirects to the M saved PC.
- R7: A supervisor return (ev_kind 3) moves to S if SPP is 1 and to U otherwise. It sets SIE to SPIE, sets SPIE to 1, SPP to 0 and MPRV to 0, and redirects to the S saved PC.
- R8: While `rd_valid` is high and `rd_ready` is low, `ev_ready` stays low and the redirect outputs hold their values. An event offered in that time changes no state.
- R9: The machine status address 0x300 writes every status field; an MPP value of 2'b10 is stored as U. The supervisor status address 0x100 reads and writes only SIE, SPIE and SPP.
- R10: A CSR write is dropped in any cycle in which an event is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_kind | input | 2 | 0 exception, 1 interrupt, 2 machine return, 3 supervisor return |
| ev_code | input | CODE_W | Cause number of a trap |
| ev_pc | input | XLEN | Address of the affected instruction |
| ev_tval | input | XLEN | Trap-specific value |
| rd_valid | output | 1 | Redirect pending |
| rd_ready | input | 1 | Consumer takes the redirect |
| rd_pc | output | XLEN | New fetch address |
| rd_priv | output | 2 | Privilege after the event |
| cur_priv | output | 2 | Current privilege |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |

## Verification
Several rules are checked by assertions on every cycle:
- a trap taken in M never leaves M;
- entry into a level clears that level's enable and saves the old enable;
- MPRV is cleared on a machine return to a lower level;
- a supervisor return never lands in M;
- the saved PC and the cause interrupt flag follow the event;
- a stalled redirect holds steady;
- the redirect privilege always matches the current privilege.

Other behaviour needs the bench's scenarios: a chain of traps and returns across U, S and M. These show the exact status words, the delegation decided by each mask, the masked supervisor status view, the legalised MPP write and the CSR write lost to a same-cycle event.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam logic [1:0] PRV_U = 2'b00;
  localparam logic [1:0] PRV_S = 2'b01;
  localparam logic [1:0] PRV_M = 2'b11;

  localparam logic [1:0] EV_EXC  = 2'd0;
  localparam logic [1:0] EV_INT  = 2'd1;
  localparam logic [1:0] EV_MRET = 2'd2;
  localparam logic [1:0] EV_SRET = 2'd3;

  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_EDELEG  = 12'h302;
  localparam logic [11:0] A_IDELEG  = 12'h303;
  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] M_BASE    = 12'h300;
  localparam logic [11:0] S_BASE    = 12'h100;

  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP  = 11;
  localparam int B_MPRV = 17;

  typedef struct packed {
    logic       mprv;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
  } status_t;

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              is_int,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        priv,
  input  logic [XLEN-1:0]   edeleg,
  input  logic [XLEN-1:0]   ideleg,
  output logic              to_s
);

  logic [XLEN-1:0] mask;

  always_comb begin
    mask = is_int ? ideleg : edeleg;
    to_s = (priv != PRV_M) && mask[code];
  end

endmodule

// File: rtl/trap_level_regs.sv
module trap_level_regs #(
  parameter int          XLEN   = 32,
  parameter int          CODE_W = 5,
  parameter logic [11:0] BASE   = 12'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              cap_int,
  input  logic [CODE_W-1:0] cap_code,
  input  logic [XLEN-1:0]   cap_pc,
  input  logic [XLEN-1:0]   cap_tval,
  input  logic              we,
  input  logic [11:0]       addr,
  input  logic [XLEN-1:0]   wdata,
  output logic              rhit,
  output logic [XLEN-1:0]   rdata,
  output logic [XLEN-1:0]   vec_base,
  output logic [XLEN-1:0]   epc
);

  localparam logic [11:0] A_VEC   = BASE | 12'h005;
  localparam logic [11:0] A_EPC   = BASE | 12'h041;
  localparam logic [11:0] A_CAUSE = BASE | 12'h042;
  localparam logic [11:0] A_TVAL  = BASE | 12'h043;
  localparam int          PADW    = XLEN - 1 - CODE_W;

  logic [XLEN-1:0] vec_q, epc_q, cause_q, tval_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q   <= '0;
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (cap) begin
      epc_q   <= cap_pc;
      cause_q <= {cap_int, {PADW{1'b0}}, cap_code};
      tval_q  <= cap_tval;
    end else if (we) begin
      case (addr)
        A_VEC:   vec_q   <= wdata;
        A_EPC:   epc_q   <= wdata;
        A_CAUSE: cause_q <= wdata;
        A_TVAL:  tval_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rhit  = 1'b1;
    rdata = '0;
    case (addr)
      A_VEC:   rdata = vec_q;
      A_EPC:   rdata = epc_q;
      A_CAUSE: rdata = cause_q;
      A_TVAL:  rdata = tval_q;
      default: rhit = 1'b0;
    endcase
  end

  assign vec_base = {vec_q[XLEN-1:2], 2'b00};
  assign epc      = epc_q;

  // R3: the captured address and value follow the event
  assert_epc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (epc_q == $past(cap_pc)) && (tval_q == $past(cap_tval)));

  // R3: interrupt flag and cause number in the cause word
  assert_cause_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (cause_q[XLEN-1] == $past(cap_int)) && (cause_q[CODE_W-1:0] == $past(cap_code)));

endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_acc,
  input  logic       trap_to_s,
  input  logic       mret_acc,
  input  logic       sret_acc,
  input  logic       wr_m,
  input  logic       wr_s,
  input  status_t    wr,
  output status_t    st,
  output logic [1:0] priv
);

  status_t    st_q;
  logic [1:0] priv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      priv_q <= PRV_M;
    end else if (trap_acc) begin
      if (trap_to_s) begin
        st_q.spie <= st_q.sie;
        st_q.sie  <= 1'b0;
        st_q.spp  <= (priv_q == PRV_S);
        priv_q    <= PRV_S;
      end else begin
        st_q.mpie <= st_q.mie;
        st_q.mie  <= 1'b0;
        st_q.mpp  <= priv_q;
        priv_q    <= PRV_M;
      end
    end else if (mret_acc) begin
      priv_q    <= st_q.mpp;
      st_q.mie  <= st_q.mpie;
      st_q.mpie <= 1'b1;
      st_q.mpp  <= PRV_U;
      if (st_q.mpp != PRV_M) st_q.mprv <= 1'b0;
    end else if (sret_acc) begin
      priv_q    <= st_q.spp ? PRV_S : PRV_U;
      st_q.sie  <= st_q.spie;
      st_q.spie <= 1'b1;
      st_q.spp  <= 1'b0;
      st_q.mprv <= 1'b0;
    end else if (wr_m) begin
      st_q     <= wr;
      st_q.mpp <= (wr.mpp == 2'b10) ? PRV_U : wr.mpp;
    end else if (wr_s) begin
      st_q.sie  <= wr.sie;
      st_q.spie <= wr.spie;
      st_q.spp  <= wr.spp;
    end
  end

  assign st   = st_q;
  assign priv = priv_q;

  // R2: no trap taken in M is handed down
  assert_m_stays_m_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_acc && priv_q == PRV_M) |=> (priv_q == PRV_M));

  // R4: M entry saves and clears the machine enable
  assert_m_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_acc && !trap_to_s) |=> (!st_q.mie && st_q.mpie == $past(st_q.mie)));

  // R4: S entry saves and clears the supervisor enable
  assert_s_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_acc && trap_to_s) |=> (!st_q.sie && st_q.spie == $past(st_q.sie)));

  // R6: return below M drops MPRV
  assert_mret_mprv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_acc && st_q.mpp != PRV_M) |=> !st_q.mprv);

  // R7: a supervisor return never reaches M
  assert_sret_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sret_acc |=> (priv_q != PRV_M));

endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [XLEN-1:0]   ev_pc,
  input  logic [XLEN-1:0]   ev_tval,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [XLEN-1:0]   rd_pc,
  output logic [1:0]        rd_priv,
  output logic [1:0]        cur_priv,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata
);

  logic            ev_acc, is_trap, is_int, is_mret, is_sret, to_s, wr_en;
  logic [XLEN-1:0] edeleg_q, ideleg_q;
  logic            rd_valid_q;
  logic [XLEN-1:0] rd_pc_q, nxt_pc;
  logic [1:0]      rd_priv_q, nxt_priv, priv;
  status_t         st, wr;
  logic            m_hit, s_hit;
  logic [XLEN-1:0] m_rdata, s_rdata, m_vec, s_vec, m_epc, s_epc;

  assign ev_ready = !rd_valid_q;
  assign ev_acc   = ev_valid && ev_ready;
  assign is_trap  = ev_acc && (ev_kind == EV_EXC || ev_kind == EV_INT);
  assign is_int   = (ev_kind == EV_INT);
  assign is_mret  = ev_acc && (ev_kind == EV_MRET);
  assign is_sret  = ev_acc && (ev_kind == EV_SRET);
  assign wr_en    = csr_we && !ev_acc;

  trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
    .is_int(is_int), .code(ev_code), .priv(priv),
    .edeleg(edeleg_q), .ideleg(ideleg_q), .to_s(to_s)
  );

  trap_level_regs #(.XLEN(XLEN), .CODE_W(CODE_W), .BASE(M_BASE)) u_mregs (
    .clk(clk), .rst_n(rst_n), .cap(is_trap && !to_s), .cap_int(is_int),
    .cap_code(ev_code), .cap_pc(ev_pc), .cap_tval(ev_tval),
    .we(wr_en), .addr(csr_addr), .wdata(csr_wdata),
    .rhit(m_hit), .rdata(m_rdata), .vec_base(m_vec), .epc(m_epc)
  );

  trap_level_regs #(.XLEN(XLEN), .CODE_W(CODE_W), .BASE(S_BASE)) u_sregs (
    .clk(clk), .rst_n(rst_n), .cap(is_trap && to_s), .cap_int(is_int),
    .cap_code(ev_code), .cap_pc(ev_pc), .cap_tval(ev_tval),
    .we(wr_en), .addr(csr_addr), .wdata(csr_wdata),
    .rhit(s_hit), .rdata(s_rdata), .vec_base(s_vec), .epc(s_epc)
  );

  always_comb begin
    wr      = '0;
    wr.sie  = csr_wdata[B_SIE];
    wr.mie  = csr_wdata[B_MIE];
    wr.spie = csr_wdata[B_SPIE];
    wr.mpie = csr_wdata[B_MPIE];
    wr.spp  = csr_wdata[B_SPP];
    wr.mpp  = csr_wdata[B_MPP+1:B_MPP];
    wr.mprv = csr_wdata[B_MPRV];
  end

  trap_status u_status (
    .clk(clk), .rst_n(rst_n), .trap_acc(is_trap), .trap_to_s(to_s),
    .mret_acc(is_mret), .sret_acc(is_sret),
    .wr_m(wr_en && csr_addr == A_MSTATUS), .wr_s(wr_en && csr_addr == A_SSTATUS),
    .wr(wr), .st(st), .priv(priv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edeleg_q <= '0;
      ideleg_q <= '0;
    end else if (wr_en) begin
      if (csr_addr == A_EDELEG) edeleg_q <= csr_wdata;
      if (csr_addr == A_IDELEG) ideleg_q <= csr_wdata;
    end
  end

  always_comb begin
    case (ev_kind)
      EV_MRET: begin nxt_pc = m_epc; nxt_priv = st.mpp; end
      EV_SRET: begin nxt_pc = s_epc; nxt_priv = st.spp ? PRV_S : PRV_U; end
      default: begin
        nxt_pc   = to_s ? s_vec : m_vec;
        nxt_priv = to_s ? PRV_S : PRV_M;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_pc_q    <= '0;
      rd_priv_q  <= PRV_M;
    end else if (ev_acc) begin
      rd_valid_q <= 1'b1;
      rd_pc_q    <= nxt_pc;
      rd_priv_q  <= nxt_priv;
    end else if (rd_ready) begin
      rd_valid_q <= 1'b0;
    end
  end

  always_comb begin
    logic [XLEN-1:0] sw;
    sw = '0;
    sw[B_SIE]  = st.sie;
    sw[B_MIE]  = st.mie;
    sw[B_SPIE] = st.spie;
    sw[B_MPIE] = st.mpie;
    sw[B_SPP]  = st.spp;
    sw[B_MPP+1:B_MPP] = st.mpp;
    sw[B_MPRV] = st.mprv;
    if (csr_addr == A_MSTATUS)      csr_rdata = sw;
    else if (csr_addr == A_SSTATUS) csr_rdata = sw & ((XLEN'(1) << B_SIE) | (XLEN'(1) << B_SPIE) | (XLEN'(1) << B_SPP));
    else if (csr_addr == A_EDELEG)  csr_rdata = edeleg_q;
    else if (csr_addr == A_IDELEG)  csr_rdata = ideleg_q;
    else if (m_hit)                 csr_rdata = m_rdata;
    else if (s_hit)                 csr_rdata = s_rdata;
    else                            csr_rdata = '0;
  end

  assign rd_valid = rd_valid_q;
  assign rd_pc    = rd_pc_q;
  assign rd_priv  = rd_priv_q;
  assign cur_priv = priv;

  // R8: a stalled redirect keeps its contents
  assert_redir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_q && !rd_ready) |=> (rd_valid_q && $stable(rd_pc_q) && $stable(rd_priv_q)));

  // R5: the redirect privilege and the live privilege agree
  assert_redir_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> (rd_priv_q == priv));

endmodule

// File: tb/sim_trap_unit.sv
`timescale 1ns/1ps
module sim_trap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [1:0]  ev_kind = '0;
  logic [4:0]  ev_code = '0;
  logic [31:0] ev_pc = '0, ev_tval = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [31:0] rd_pc;
  logic [1:0]  rd_priv, cur_priv;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit [33:0] exp_q[$];

  always #4 clk = ~clk;

  trap_unit u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic csr_wr(logic [11:0] a, logic [31:0] d);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    step();
    csr_we = 0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    csr_addr = a; #1;
    chk(tag, csr_rdata, exp);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) step();
    step();
  endtask

  task automatic send(logic [1:0] k, logic [4:0] c, logic [31:0] pc, logic [31:0] tv,
                      logic [31:0] epc_exp, logic [1:0] pr_exp);
    while (!ev_ready) step();
    ev_valid = 1; ev_kind = k; ev_code = c; ev_pc = pc; ev_tval = tv;
    exp_q.push_back({pr_exp, epc_exp});
    step();
    ev_valid = 0;
    drain();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected redirect", 32'h1, 32'h0);
      else begin
        bit [33:0] e;
        e = exp_q.pop_front();
        chk("R5 redirect pc", rd_pc, e[31:0]);
        chk("R5 redirect priv", {30'd0, rd_priv}, {30'd0, e[33:32]});
        chk("R5 cur_priv", {30'd0, cur_priv}, {30'd0, e[33:32]});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    // R1 reset state
    chk("R1 priv", {30'd0, cur_priv}, 32'h3);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'h0);
    chk("R1 ev_ready", {31'd0, ev_ready}, 32'h1);
    rd_chk("R1 mstatus", 12'h300, 32'h0);
    rd_chk("R1 mtvec", 12'h305, 32'h0);

    csr_wr(12'h305, 32'h1000_0001);
    csr_wr(12'h105, 32'h2000_0102);
    csr_wr(12'h302, 32'h0000_0104);
    csr_wr(12'h303, 32'h0000_0020);
    csr_wr(12'h300, 32'h0000_0008);

    // R2: delegated code taken in M stays in M
    send(2'd0, 5'd8, 32'h100, 32'h11, 32'h1000_0000, 2'b11);
    rd_chk("R3 mepc", 12'h341, 32'h100);
    rd_chk("R3 mcause", 12'h342, 32'h8);
    rd_chk("R3 mtval", 12'h343, 32'h11);
    rd_chk("R3 sepc untouched", 12'h141, 32'h0);
    rd_chk("R4 mstatus after M entry", 12'h300, 32'h1880);

    // R6: machine return to U clears MPRV
    csr_wr(12'h300, 32'h0002_0080);
    rd_chk("R9 mstatus write", 12'h300, 32'h0002_0080);
    csr_wr(12'h341, 32'h400);
    send(2'd2, 5'd0, 32'h0, 32'h0, 32'h400, 2'b00);
    rd_chk("R6 mstatus after mret", 12'h300, 32'h88);

    // R9: supervisor view masks other fields
    csr_wr(12'h100, 32'h0000_1802);
    rd_chk("R9 mstatus via sstatus", 12'h300, 32'h8A);
    rd_chk("R9 sstatus read", 12'h100, 32'h2);

    // R2: delegated exception from U goes to S
    send(2'd0, 5'd8, 32'h404, 32'h0, 32'h2000_0100, 2'b01);
    rd_chk("R3 sepc", 12'h141, 32'h404);
    rd_chk("R3 scause", 12'h142, 32'h8);
    rd_chk("R3 mepc untouched", 12'h341, 32'h400);
    rd_chk("R4 mstatus after S entry", 12'h300, 32'hA8);

    // R2: delegated interrupt from S stays in S
    send(2'd1, 5'd5, 32'h2000_0104, 32'h0, 32'h2000_0100, 2'b01);
    rd_chk("R3 scause int flag", 12'h142, 32'h8000_0005);
    rd_chk("R4 SPP set from S", 12'h300, 32'h188);

    // R2: non-delegated exception from S goes to M
    send(2'd0, 5'd3, 32'h2000_0108, 32'hDEAD, 32'h1000_0000, 2'b11);
    rd_chk("R3 mcause", 12'h342, 32'h3);
    rd_chk("R3 mtval", 12'h343, 32'hDEAD);
    rd_chk("R4 MPP=S", 12'h300, 32'h980);

    send(2'd2, 5'd0, 32'h0, 32'h0, 32'h2000_0108, 2'b01);
    rd_chk("R6 mstatus mret to S", 12'h300, 32'h188);

    // R7: supervisor returns to S then to U
    send(2'd3, 5'd0, 32'h0, 32'h0, 32'h2000_0104, 2'b01);
    rd_chk("R7 mstatus sret to S", 12'h300, 32'hA8);
    send(2'd3, 5'd0, 32'h0, 32'h0, 32'h2000_0104, 2'b00);
    rd_chk("R7 mstatus sret to U", 12'h300, 32'hAA);

    // R2: non-delegated interrupt from U goes to M
    send(2'd1, 5'd7, 32'h500, 32'h77, 32'h1000_0000, 2'b11);
    rd_chk("R3 mcause int", 12'h342, 32'h8000_0007);
    rd_chk("R4 mstatus", 12'h300, 32'hA2);

    // R8: back-pressure
    rd_ready = 0;
    ev_valid = 1; ev_kind = 2'd2; ev_code = 0; ev_pc = 0; ev_tval = 0;
    exp_q.push_back({2'b00, 32'h500});
    step();
    ev_kind = 2'd0; ev_code = 5'd3; ev_pc = 32'h900; ev_tval = 32'h9;
    for (int i = 0; i < 3; i++) begin
      chk("R8 ev_ready low", {31'd0, ev_ready}, 32'h0);
      chk("R8 rd_valid held", {31'd0, rd_valid}, 32'h1);
      chk("R8 rd_pc held", rd_pc, 32'h500);
      step();
    end
    ev_valid = 0;
    rd_ready = 1;
    drain();
    rd_chk("R8 mcause untouched", 12'h342, 32'h8000_0007);
    rd_chk("R8 mepc untouched", 12'h341, 32'h500);
    chk("R8 priv", {30'd0, cur_priv}, 32'h0);
    rd_chk("R6 mstatus after stalled mret", 12'h300, 32'hAA);

    // R9: MPP legalisation
    csr_wr(12'h300, 32'h1000);
    rd_chk("R9 MPP 10 -> U", 12'h300, 32'h0);
    csr_wr(12'h300, 32'h1800);
    rd_chk("R9 MPP 11 kept", 12'h300, 32'h1800);
    csr_wr(12'h300, 32'h0);

    // R10: CSR write lost to same-cycle event
    while (!ev_ready) step();
    ev_valid = 1; ev_kind = 2'd0; ev_code = 5'd2; ev_pc = 32'h600; ev_tval = 32'h3;
    csr_we = 1; csr_addr = 12'h343; csr_wdata = 32'h55;
    exp_q.push_back({2'b01, 32'h2000_0100});
    step();
    ev_valid = 0; csr_we = 0;
    drain();
    rd_chk("R10 mtval kept", 12'h343, 32'h77);
    rd_chk("R3 stval", 12'h143, 32'h3);
    rd_chk("R3 scause", 12'h142, 32'h2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule